// File: doc/BRIEF.md
# Real-Time Clock Control, Status and Seconds Prescaler

This block is the control and status register of a real-time clock, together with the prescaler that turns a reference tick into the one-per-second increment for the time-of-day counter. Software reaches it through one 8-bit register with a read strobe and a write strobe. The register selects the tick source, either a 32 kHz crystal tick or a power-line tick at 50 Hz or 60 Hz. It also selects BCD or binary counting for the counter chain, gates the alarm interrupt, and holds the write-protect unlock bit for the counter.

The alarm flag tracks a match pulse from the time/alarm comparator. The flag is sampled only when the count increments or when the unlock bit is cleared again. Between those moments the flag holds its value. Reading the register returns the flags and then clears them on the following edge. A flag-setting event in the same cycle as a read wins over the clear. A wake flag records that an alarm arrived while the device was asleep, and it survives reset. Every write restarts the prescaler from zero, so the second boundary can be aligned to an outside time reference.

Top module: `rtcctl_top`

## Requirements
- R1: The register reads as bit 7 alarm flag, bit 6 interrupt enable, bit 5 BCD select, bit 4 source select (0 crystal, 1 power line), bit 3 line rate (0 for 60 Hz, 1 for 50 Hz), bit 2 spare read/write, bit 1 wake flag, bit 0 unlock. Writes load bits 6, 5, 4, 3, 2 and 0, and writes do not change bits 7 and 1.
- R2: Reset clears the interrupt enable and the unlock bit. It leaves the BCD select, source select, line rate, spare bit, alarm flag and wake flag unchanged.
- R3: With the crystal source, `osc_en` is 1 and `sec_tick` pulses for one cycle every 32768 `xtal_tick` pulses. `line_tick` has no effect.
- R4: With the power-line source, `osc_en` is 0 and `sec_tick` pulses once every 60 `line_tick` pulses (rate bit 0) or every 50 pulses (rate bit 1). `xtal_tick` has no effect.
- R5: Any register write restarts the prescaler at zero.
- R6: The alarm flag loads `alarm_match` in the cycle `sec_tick` is high, or on a write that clears the unlock bit while it was 1. At all other times the flag holds its value.
- R7: A read returns the flag values from before the clear. The alarm and wake flags clear on the edge that ends the read strobe.
- R8: When a flag-setting event falls in the same cycle as a read, the flag is set.
- R9: `alarm_irq` is high exactly when both the alarm flag and the interrupt enable are 1.
- R10: The wake flag sets when the alarm flag samples a match while `sleep_mode` is high.
- R11: `bcd_mode` follows register bit 5.
- R12: `cnt_unlock` follows register bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Register contents |
| xtal_tick | input | 1 | 32 kHz reference tick, one cycle per pulse |
| line_tick | input | 1 | Power-line tick, one cycle per pulse |
| alarm_match | input | 1 | Time equals alarm set point |
| sleep_mode | input | 1 | Device is in sleep mode |
| sec_tick | output | 1 | One-cycle seconds increment |
| bcd_mode | output | 1 | BCD counting select for the counter chain |
| osc_en | output | 1 | Crystal oscillator enable |
| alarm_irq | output | 1 | Alarm interrupt |
| cnt_unlock | output | 1 | Counter write-protect release |
| alarm_flag | output | 1 | Alarm status flag |
| wake_flag | output | 1 | Wake-from-sleep status flag |

## Verification
The bench holds `alarm_match` high while no increment or relock happens. A design that samples the match on every cycle would set the alarm early. The bench issues a read and a relock write in the same cycle. A design that lets the clear win would lose that alarm. It writes the control register part-way through a line period and then counts pulses. A prescaler that was not restarted would tick 40 pulses too soon. It also applies reset with the alarm flag, the wake flag and the BCD select all set. A design that reset those bits would read back zeros where ones are expected.

// File: rtl/rtcctl_pkg.sv
package rtcctl_pkg;

    typedef enum logic {
        SRC_XTAL = 1'b0,
        SRC_LINE = 1'b1
    } clk_src_e;

    // Writable control fields, packed in register bit order 6..2, 0
    typedef struct packed {
        logic     int_en;
        logic     bcd;
        clk_src_e src;
        logic     line50;
        logic     spare;
        logic     unlock;
    } ctrl_t;

    typedef struct packed {
        logic alarm;
        logic wake;
    } flags_t;

    function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
        ctrl_t c;
        c.int_en = b[6];
        c.bcd    = b[5];
        c.src    = clk_src_e'(b[4]);
        c.line50 = b[3];
        c.spare  = b[2];
        c.unlock = b[0];
        return c;
    endfunction

    function automatic logic [7:0] reg_image(input ctrl_t c, input flags_t f);
        return {f.alarm, c.int_en, c.bcd, c.src, c.line50, c.spare, f.wake, c.unlock};
    endfunction

endpackage

// File: rtl/rtcctl_regs.sv
module rtcctl_regs
    import rtcctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wdata,
    output ctrl_t      ctrl,
    output logic       relock
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.int_en <= 1'b0;
            ctrl_q.unlock <= 1'b0;
        end else if (wr) begin
            ctrl_q <= ctrl_from_byte(wdata);
        end
    end

    assign ctrl   = ctrl_q;
    assign relock = wr && !rst && ctrl_q.unlock && !wdata[0];

    p_wr_load_r1: assert property (@(posedge clk) disable iff (rst)
        wr |=> (ctrl_q.bcd == $past(wdata[5]) && ctrl_q.unlock == $past(wdata[0])));

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ctrl_q));

endmodule

// File: rtl/rtcctl_prescale.sv
module rtcctl_prescale
    import rtcctl_pkg::*;
#(
    parameter int unsigned XTAL_DIV   = 32768,
    parameter int unsigned LINE60_DIV = 60,
    parameter int unsigned LINE50_DIV = 50
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  clk_src_e src,
    input  logic     line50,
    input  logic     xtal_tick,
    input  logic     line_tick,
    output logic     sec_tick
);

    localparam int unsigned LINE_MAX = (LINE60_DIV > LINE50_DIV) ? LINE60_DIV : LINE50_DIV;
    localparam int unsigned MAX_DIV  = (XTAL_DIV > LINE_MAX) ? XTAL_DIV : LINE_MAX;
    localparam int unsigned CW       = $clog2(MAX_DIV);
    localparam logic [CW-1:0] XT_LAST = CW'(XTAL_DIV - 1);
    localparam logic [CW-1:0] L60_LAST = CW'(LINE60_DIV - 1);
    localparam logic [CW-1:0] L50_LAST = CW'(LINE50_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          tick_in;
    logic          wrap;
    logic          sec_q;

    always_comb begin
        if (src == SRC_XTAL) begin
            tick_in = xtal_tick;
            last    = XT_LAST;
        end else begin
            tick_in = line_tick;
            last    = line50 ? L50_LAST : L60_LAST;
        end
    end

    assign wrap = tick_in && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
            sec_q <= 1'b0;
        end else begin
            sec_q <= wrap;
            if (wrap)
                cnt_q <= '0;
            else if (tick_in)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sec_tick = sec_q;

    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0 && !sec_tick));

    p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (rst || restart)
        !tick_in |=> $stable(cnt_q));

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);

endmodule

// File: rtl/rtcctl_flags.sv
module rtcctl_flags
    import rtcctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sample,
    input  logic   match,
    input  logic   sleeping,
    input  logic   rd,
    output flags_t flags
);

    flags_t f_q;
    logic   rd_ok;

    assign rd_ok = rd && !rst;

    always_ff @(posedge clk) begin
        if (sample)
            f_q.alarm <= match;
        else if (rd_ok)
            f_q.alarm <= 1'b0;

        if (sample && match && sleeping)
            f_q.wake <= 1'b1;
        else if (rd_ok)
            f_q.wake <= 1'b0;
    end

    assign flags = f_q;

    p_alarm_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!sample && !rd) |=> $stable(f_q.alarm));

    p_read_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (rd && !sample) |=> (!f_q.alarm && !f_q.wake));

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (sample && match) |=> f_q.alarm);

    p_wake_set_r10: assert property (@(posedge clk) disable iff (rst)
        (sample && match && sleeping) |=> f_q.wake);

endmodule

// File: rtl/rtcctl_top.sv
module rtcctl_top
    import rtcctl_pkg::*;
#(
    parameter int unsigned XTAL_DIV   = 32768,
    parameter int unsigned LINE60_DIV = 60,
    parameter int unsigned LINE50_DIV = 50
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       xtal_tick,
    input  logic       line_tick,
    input  logic       alarm_match,
    input  logic       sleep_mode,
    output logic       sec_tick,
    output logic       bcd_mode,
    output logic       osc_en,
    output logic       alarm_irq,
    output logic       cnt_unlock,
    output logic       alarm_flag,
    output logic       wake_flag
);

    ctrl_t  ctrl;
    flags_t flags;
    logic   relock;
    logic   wr_ok;

    assign wr_ok = reg_wr && !rst;

    rtcctl_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .wdata  (wdata),
        .ctrl   (ctrl),
        .relock (relock)
    );

    rtcctl_prescale #(
        .XTAL_DIV   (XTAL_DIV),
        .LINE60_DIV (LINE60_DIV),
        .LINE50_DIV (LINE50_DIV)
    ) u_pre (
        .clk       (clk),
        .rst       (rst),
        .restart   (wr_ok),
        .src       (ctrl.src),
        .line50    (ctrl.line50),
        .xtal_tick (xtal_tick),
        .line_tick (line_tick),
        .sec_tick  (sec_tick)
    );

    rtcctl_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .sample   (sec_tick || relock),
        .match    (alarm_match),
        .sleeping (sleep_mode),
        .rd       (reg_rd),
        .flags    (flags)
    );

    assign rdata      = reg_image(ctrl, flags);
    assign bcd_mode   = ctrl.bcd;
    assign osc_en     = (ctrl.src == SRC_XTAL);
    assign alarm_irq  = flags.alarm && ctrl.int_en;
    assign cnt_unlock = ctrl.unlock;
    assign alarm_flag = flags.alarm;
    assign wake_flag  = flags.wake;

    p_irq_needs_alarm_r9: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> (rdata[7] && rdata[6]));

    p_reset_clears_r2: assert property (@(posedge clk)
        rst |=> (!rdata[6] && !rdata[0]));

endmodule

// File: tb/rtcctl_top_test.sv
module rtcctl_top_test;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       xtal_tick = 1'b0, line_tick = 1'b0;
    logic       alarm_match = 1'b0, sleep_mode = 1'b0;
    logic       sec_tick, bcd_mode, osc_en, alarm_irq, cnt_unlock, alarm_flag, wake_flag;

    int checks = 0;
    int errors = 0;
    int ticks  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtcctl_top uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .wdata(wdata),
        .rdata(rdata), .xtal_tick(xtal_tick), .line_tick(line_tick),
        .alarm_match(alarm_match), .sleep_mode(sleep_mode), .sec_tick(sec_tick),
        .bcd_mode(bcd_mode), .osc_en(osc_en), .alarm_irq(alarm_irq),
        .cnt_unlock(cnt_unlock), .alarm_flag(alarm_flag), .wake_flag(wake_flag)
    );

    always @(posedge clk) if (sec_tick) ticks <= ticks + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        reg_wr = 1'b1; wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(output logic [7:0] d);
        reg_rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_line(input int n);
        for (int i = 0; i < n; i++) begin
            line_tick = 1'b1; @(negedge clk);
            line_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rst = 1'b1; idle(3); rst = 1'b0;
        do_read(d);
        check("R2 int_en after reset", d[6], 1'b0);
        check("R2 unlock after reset", d[0], 1'b0);
        check("R9 irq after reset", alarm_irq, 1'b0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        do_write(8'h6D);
        do_read(d);
        check("R1 readback 6D", d, 8'h6D);
        do_write(8'hFF);
        do_read(d);
        check("R1 bits 7,1 ignore writes", d, 8'h7D);
        check("R11 bcd_mode", bcd_mode, 1'b1);
        check("R12 cnt_unlock", cnt_unlock, 1'b1);
        do_write(8'h00);
        check("R11 bcd_mode off", bcd_mode, 1'b0);
        check("R12 cnt_unlock off", cnt_unlock, 1'b0);
    endtask

    task automatic t_line();
        int t0;
        do_write(8'h10);
        xtal_tick = 1'b1;
        check("R4 osc_en line", osc_en, 1'b0);
        t0 = ticks;
        pulse_line(59);
        check("R4 60Hz no tick at 59", ticks - t0, 0);
        pulse_line(1); idle(2);
        check("R4 60Hz tick at 60", ticks - t0, 1);
        do_write(8'h18);
        t0 = ticks;
        pulse_line(49); idle(2);
        check("R4 50Hz no tick at 49", ticks - t0, 0);
        pulse_line(1); idle(2);
        check("R4 50Hz tick at 50", ticks - t0, 1);
        xtal_tick = 1'b0;
    endtask

    task automatic t_restart();
        int t0;
        do_write(8'h10);
        t0 = ticks;
        pulse_line(40);
        do_write(8'h10);
        pulse_line(40); idle(2);
        check("R5 write restarts prescaler", ticks - t0, 0);
        pulse_line(20); idle(2);
        check("R5 tick after full period", ticks - t0, 1);
    endtask

    task automatic t_xtal();
        int t0;
        do_write(8'h00);
        xtal_tick = 1'b1; line_tick = 1'b1;
        t0 = ticks;
        check("R3 osc_en crystal", osc_en, 1'b1);
        idle(32766);
        check("R3 no tick before 32768", ticks - t0, 0);
        idle(4);
        check("R3 tick at 32768", ticks - t0, 1);
        xtal_tick = 1'b0; line_tick = 1'b0;
    endtask

    task automatic t_alarm_sample();
        logic [7:0] d;
        do_write(8'h50);
        alarm_match = 1'b1;
        idle(3);
        check("R6 no sample without increment", alarm_flag, 1'b0);
        pulse_line(60); idle(2);
        check("R6 sampled on increment", alarm_flag, 1'b1);
        check("R9 irq with enable", alarm_irq, 1'b1);
        alarm_match = 1'b0;
        idle(3);
        check("R6 holds after match drops", alarm_flag, 1'b1);
        do_read(d);
        check("R7 read shows pre-clear alarm", d[7], 1'b1);
        check("R7 alarm cleared by read", alarm_flag, 1'b0);
        check("R9 irq cleared by read", alarm_irq, 1'b0);
    endtask

    task automatic t_relock();
        logic [7:0] d;
        do_write(8'h11);
        alarm_match = 1'b1;
        idle(2);
        check("R6 no sample while unlocked", alarm_flag, 1'b0);
        do_write(8'h10);
        check("R6 sampled on relock", alarm_flag, 1'b1);
        check("R9 irq gated off", alarm_irq, 1'b0);
        do_write(8'h11);
        reg_rd = 1'b1; reg_wr = 1'b1; wdata = 8'h10;
        #1 d = rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0;
        check("R8 read data in collision", d[7], 1'b1);
        check("R8 set wins over read clear", alarm_flag, 1'b1);
        alarm_match = 1'b0;
        do_read(d);
        check("R7 clear after collision", alarm_flag, 1'b0);
    endtask

    task automatic t_wake();
        logic [7:0] d;
        do_write(8'h71);
        sleep_mode = 1'b1; alarm_match = 1'b1;
        do_write(8'h70);
        sleep_mode = 1'b0; alarm_match = 1'b0;
        check("R10 wake set", wake_flag, 1'b1);
        rst = 1'b1; idle(3); rst = 1'b0;
        check("R2 wake kept over reset", wake_flag, 1'b1);
        do_read(d);
        check("R2 register after reset", d, 8'hB2);
        do_read(d);
        check("R7 wake and alarm cleared", d, 8'h30);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_regs();
        t_line();
        t_restart();
        t_xtal();
        t_alarm_sample();
        t_relock();
        t_wake();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule